// File: doc/BRIEF.md
# Programmable Trigger Combiner

This block decides, every clock cycle, whether a probe vector under observation is a trigger event for a logic analyzer. A set of match terms each compare the probe against a programmed value, and only the bits their masks select take part. One edge unit looks at the probe and at the probe from the previous cycle. Under three masks of its own it reports whether any selected bit rose, fell or changed. The match bits and the three edge flags together form an index into a lookup table that software fills at run time. Any boolean function of the sources can therefore act as the trigger without changing the logic.

The table is loaded through a single packed word in two steps. A word with its enable bit set makes an entry pending. The next word with that bit clear commits it. This is done by a small loader state machine with two states. LD_IDLE moves to LD_PEND on an enable-set write. LD_PEND stays in LD_PEND on another enable-set write, which replaces the pending entry. LD_PEND returns to LD_IDLE on an enable-clear write, which commits the entry. In LD_IDLE, enable-clear writes are dropped. The looked-up entry is registered to form `hit_o`. A one-cycle `hit_start_o` marks the cycle in which `hit_o` goes from 0 to 1, because a capture side starts on that edge and not on the level.

Top module: `probe_trigger`

## Requirements
- R1: Match term k is true when `((probe_i ^ value_k) & mask_k) == 0`, so only bits set in its mask are compared.
- R2: After reset every term mask is all ones and every term value is zero. All three edge masks are zero, every table entry is 0, and `hit_o` and `hit_start_o` are 0.
- R3: A cycle with `term_wr_i` high loads `term_mask_i` and `term_value_i` into term `term_sel_i` only. A term's mask and value do not change without such a write.
- R4: The rise flag is the OR over bits of `rise_mask & probe & ~prev`. The fall flag is the OR of `fall_mask & ~probe & prev`. `prev` is the probe value of the previous cycle, and it is 0 in the first cycle after reset.
- R5: The change flag is the OR over bits of `change_mask & (probe ^ prev)`.
- R6: A cycle with `edge_wr_i` high loads `edge_mask_i` into the mask chosen by `edge_kind_i`: 0 selects rise, 1 selects fall, 2 selects change. Kind 3 changes no mask.
- R7: The table index has bit k equal to match term k for k below N_TERMS. Bit N_TERMS is the rise flag, bit N_TERMS+1 the fall flag and bit N_TERMS+2 the change flag. The table holds 2^(N_TERMS+3) one-bit entries.
- R8: In `tbl_word_i`, bit 17 is the enable, bit 16 the entry value and bits [N_TERMS+2:0] the entry index. A write with bit 17 set makes that entry pending and leaves the table unchanged.
- R9: A write with bit 17 clear commits the pending entry's index and value, whatever its own other fields hold, and then nothing is pending. If nothing is pending, a write with bit 17 clear is dropped.
- R10: `hit_o` after a clock edge equals the table entry addressed by the index formed from the probe and configuration in effect before that edge.
- R11: `hit_start_o` is high for exactly the cycles in which `hit_o` is 1 and was 0 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| probe_i | input | PROBE_W | Probe vector under observation |
| term_wr_i | input | 1 | Term configuration write strobe |
| term_sel_i | input | TSEL_W | Term selected by the write |
| term_mask_i | input | PROBE_W | Mask to load |
| term_value_i | input | PROBE_W | Compare value to load |
| edge_wr_i | input | 1 | Edge mask write strobe |
| edge_kind_i | input | 2 | Edge mask chosen: 0 rise, 1 fall, 2 change, 3 none |
| edge_mask_i | input | PROBE_W | Edge mask to load |
| tbl_wr_i | input | 1 | Table word write strobe |
| tbl_word_i | input | 18 | Packed table word: enable, value, index |
| hit_o | output | 1 | Registered trigger hit |
| hit_start_o | output | 1 | One-cycle mark of the rise of `hit_o` |

## Verification
The assertions assume that each write strobe is a single-cycle pulse with its data stable in that cycle. They also assume that `edge_kind_i` and the index field of `tbl_word_i` hold defined values whenever a strobe is high. The stimulus drives every input at the falling clock edge and raises each strobe for exactly one cycle before it is cleared. It only draws table indices inside the table range. Random probes, term settings and table contents are mixed with directed sequences that cover the load ordering, the masked edges and the dropped kind-3 write.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2,
        EDGE_NONE = 2'd3
    } edge_kind_e;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_PEND = 1'b1
    } load_state_e;

    localparam int WORD_W  = 18;
    localparam int EN_BIT  = 17;
    localparam int VAL_BIT = 16;
    localparam int N_EDGE  = 3;

endpackage

// File: rtl/trig_match_term.sv
module trig_match_term #(
    parameter int PROBE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [PROBE_W-1:0] mask_i,
    input  logic [PROBE_W-1:0] value_i,
    input  logic [PROBE_W-1:0] probe_i,
    output logic               match_o
);

    logic [PROBE_W-1:0] mask_q;
    logic [PROBE_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            value_q <= '0;
        end else if (wr_i) begin
            mask_q  <= mask_i;
            value_q <= value_i;
        end
    end

    always_comb begin
        match_o = ~|((probe_i ^ value_q) & mask_q);
    end

    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(mask_q) && $stable(value_q))); // R3

endmodule

// File: rtl/trig_edge_unit.sv
module trig_edge_unit
    import trig_pkg::*;
#(
    parameter int PROBE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         kind_i,
    input  logic [PROBE_W-1:0] mask_i,
    input  logic [PROBE_W-1:0] probe_i,
    output logic               rise_o,
    output logic               fall_o,
    output logic               any_o
);

    logic [PROBE_W-1:0] emask_q [N_EDGE];
    logic [PROBE_W-1:0] prev_q;

    for (genvar j = 0; j < N_EDGE; j++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                emask_q[j] <= '0;
            end else if (wr_i && (kind_i == 2'(j))) begin
                emask_q[j] <= mask_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= probe_i;
    end

    always_comb begin
        rise_o = |(emask_q[EDGE_RISE] & probe_i & ~prev_q);
        fall_o = |(emask_q[EDGE_FALL] & ~probe_i & prev_q);
        any_o  = |(emask_q[EDGE_ANY] & (probe_i ^ prev_q));
    end

    AST_KIND_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == EDGE_NONE) |=>
        ($stable(emask_q[0]) && $stable(emask_q[1]) && $stable(emask_q[2]))); // R6

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_q == $past(probe_i))); // R4

endmodule

// File: rtl/trig_table_loader.sv
module trig_table_loader
    import trig_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              entry_o
);

    localparam int TBL_N = 1 << IDX_W;

    load_state_e       state_q, state_d;
    logic [TBL_N-1:0]  tbl_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic              pend_val_q;
    logic              set_wr, clr_wr, commit;

    if (IDX_W < VAL_BIT) begin : g_spare
        logic unused_word_bits;
        assign unused_word_bits = ^word_i[VAL_BIT-1:IDX_W];
    end

    assign set_wr = wr_i &&  word_i[EN_BIT];
    assign clr_wr = wr_i && !word_i[EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (set_wr) state_d = LD_PEND;
            end
            LD_PEND: begin
                if (clr_wr) begin
                    state_d = LD_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx_q <= '0;
            pend_val_q <= 1'b0;
        end else if (set_wr) begin
            pend_idx_q <= word_i[IDX_W-1:0];
            pend_val_q <= word_i[VAL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      tbl_q <= '0;
        else if (commit) tbl_q[pend_idx_q] <= pend_val_q;
    end

    assign entry_o = tbl_q[idx_i];

    AST_SET_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> $stable(tbl_q)); // R8

    AST_COMMIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_PEND && clr_wr) |=>
        (tbl_q[$past(pend_idx_q)] == $past(pend_val_q))); // R9

    AST_IDLE_CLEAR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE && !set_wr) |=> $stable(tbl_q)); // R9

endmodule

// File: rtl/probe_trigger.sv
module probe_trigger
    import trig_pkg::*;
#(
    parameter int PROBE_W = 16,
    parameter int N_TERMS = 4,
    localparam int TSEL_W = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
    localparam int IDX_W  = N_TERMS + N_EDGE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               term_wr_i,
    input  logic [TSEL_W-1:0]  term_sel_i,
    input  logic [PROBE_W-1:0] term_mask_i,
    input  logic [PROBE_W-1:0] term_value_i,
    input  logic               edge_wr_i,
    input  logic [1:0]         edge_kind_i,
    input  logic [PROBE_W-1:0] edge_mask_i,
    input  logic               tbl_wr_i,
    input  logic [17:0]        tbl_word_i,
    output logic               hit_o,
    output logic               hit_start_o
);

    logic [N_TERMS-1:0] term_hit;
    logic               rise_f, fall_f, any_f;
    logic [IDX_W-1:0]   tbl_idx;
    logic               entry;
    logic               hit_q, hit_d;

    for (genvar k = 0; k < N_TERMS; k++) begin : g_term
        trig_match_term #(.PROBE_W(PROBE_W)) u_term (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (term_wr_i && (term_sel_i == TSEL_W'(k))),
            .mask_i  (term_mask_i),
            .value_i (term_value_i),
            .probe_i (probe_i),
            .match_o (term_hit[k])
        );
    end

    trig_edge_unit #(.PROBE_W(PROBE_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (edge_wr_i),
        .kind_i  (edge_kind_i),
        .mask_i  (edge_mask_i),
        .probe_i (probe_i),
        .rise_o  (rise_f),
        .fall_o  (fall_f),
        .any_o   (any_f)
    );

    assign tbl_idx = {any_f, fall_f, rise_f, term_hit};

    trig_table_loader #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tbl_wr_i),
        .word_i  (tbl_word_i),
        .idx_i   (tbl_idx),
        .entry_o (entry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            hit_d <= 1'b0;
        end else begin
            hit_q <= entry;
            hit_d <= hit_q;
        end
    end

    assign hit_o       = hit_q;
    assign hit_start_o = hit_q & ~hit_d;

    AST_HIT_FOLLOWS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_o == $past(entry))); // R10

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_start_o |=> !hit_start_o); // R11

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> hit_start_o); // R11

endmodule

// File: tb/tb_probe_trigger.sv
`timescale 1ns/1ps
module tb_probe_trigger;

    localparam int PW     = 16;
    localparam int NT     = 4;
    localparam int TSW    = 2;
    localparam int IW     = NT + 3;
    localparam int TBL_N  = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] probe = '0;
    logic          term_wr = 1'b0;
    logic [TSW-1:0] term_sel = '0;
    logic [PW-1:0] term_mask = '0;
    logic [PW-1:0] term_value = '0;
    logic          edge_wr = 1'b0;
    logic [1:0]    edge_kind = '0;
    logic [PW-1:0] edge_mask = '0;
    logic          tbl_wr = 1'b0;
    logic [17:0]   tbl_word = '0;
    logic          hit_o, hit_start_o;

    always #2.5 clk = ~clk;

    probe_trigger #(.PROBE_W(PW), .N_TERMS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe),
        .term_wr_i(term_wr), .term_sel_i(term_sel),
        .term_mask_i(term_mask), .term_value_i(term_value),
        .edge_wr_i(edge_wr), .edge_kind_i(edge_kind), .edge_mask_i(edge_mask),
        .tbl_wr_i(tbl_wr), .tbl_word_i(tbl_word),
        .hit_o(hit_o), .hit_start_o(hit_start_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int cyc      = 0;

    logic [PW-1:0] m_mask [NT];
    logic [PW-1:0] m_val  [NT];
    logic [PW-1:0] m_emask [3];
    bit            m_tbl [TBL_N];
    bit            m_pend;
    logic [IW-1:0] m_pidx;
    bit            m_pval;
    logic [PW-1:0] m_prev;
    bit            m_last_hit;

    function automatic logic [IW-1:0] model_index(logic [PW-1:0] p);
        logic [IW-1:0] ix;
        for (int k = 0; k < NT; k++) ix[k] = (((p ^ m_val[k]) & m_mask[k]) == '0);
        ix[NT]   = |(m_emask[0] & p & ~m_prev);
        ix[NT+1] = |(m_emask[1] & ~p & m_prev);
        ix[NT+2] = |(m_emask[2] & (p ^ m_prev));
        return ix;
    endfunction

    task automatic check(logic act, logic exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NT; k++) begin m_mask[k] = '1; m_val[k] = '0; end
        for (int j = 0; j < 3; j++) m_emask[j] = '0;
        for (int i = 0; i < TBL_N; i++) m_tbl[i] = 1'b0;
        m_pend = 1'b0; m_pidx = '0; m_pval = 1'b0;
        m_prev = '0; m_last_hit = 1'b0;
    endtask

    // one clock: compute expectation, update model, compare after the edge
    task automatic tick(string tag);
        bit exp_hit, exp_start;
        exp_hit   = m_tbl[model_index(probe)];
        exp_start = exp_hit && !m_last_hit;
        if (term_wr) begin m_mask[term_sel] = term_mask; m_val[term_sel] = term_value; end
        if (edge_wr && edge_kind != 2'd3) m_emask[edge_kind] = edge_mask;
        if (tbl_wr) begin
            if (tbl_word[17]) begin
                m_pend = 1'b1; m_pidx = tbl_word[IW-1:0]; m_pval = tbl_word[16];
            end else if (m_pend) begin
                m_tbl[m_pidx] = m_pval; m_pend = 1'b0;
            end
        end
        m_prev = probe;
        @(negedge clk);
        check(hit_o, exp_hit, tag);
        check(hit_start_o, exp_start, "R11");
        m_last_hit = exp_hit;
        term_wr = 1'b0; edge_wr = 1'b0; tbl_wr = 1'b0;
    endtask

    task automatic tbl_write(bit en, bit val, logic [IW-1:0] ix, string tag);
        tbl_wr = 1'b1;
        tbl_word = '0;
        tbl_word[17] = en; tbl_word[16] = val; tbl_word[IW-1:0] = ix;
        tick(tag);
    endtask

    task automatic load_table(int mode);
        for (int i = 0; i < TBL_N; i++) begin
            bit v;
            case (mode)
                1: v = i[NT];
                2: v = i[NT+1];
                3: v = i[NT+2];
                default: v = 1'($urandom);
            endcase
            tbl_write(1'b1, v, IW'(i), "R8");
            tbl_write(1'b0, 1'($urandom), IW'($urandom), "R9");
        end
    endtask

    task automatic term_write(int k, logic [PW-1:0] msk, logic [PW-1:0] val);
        term_wr = 1'b1; term_sel = TSW'(k); term_mask = msk; term_value = val;
        tick("R3");
    endtask

    task automatic edge_write(int kind, logic [PW-1:0] msk, string tag);
        edge_wr = 1'b1; edge_kind = 2'(kind); edge_mask = msk;
        tick(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(hit_o, 1'b0, "R2");
        check(hit_start_o, 1'b0, "R2");

        // empty table: no hit for random probes (R2)
        for (int i = 0; i < 20; i++) begin probe = PW'($urandom); tick("R2"); end

        // pending entry does not touch the table (R8), then commit (R9)
        probe = '0;
        tbl_write(1'b1, 1'b1, IW'(15), "R8");
        tick("R8");
        tbl_write(1'b0, 1'b0, IW'(0), "R9");
        tick("R9");
        tick("R2");
        // clear write with nothing pending is dropped
        tbl_write(1'b0, 1'b0, IW'(15), "R9");
        tick("R9");
        // second set write replaces the pending entry
        tbl_write(1'b1, 1'b1, IW'(3), "R9");
        tbl_write(1'b1, 1'b0, IW'(15), "R9");
        tbl_write(1'b0, 1'b1, IW'(3), "R9");
        tick("R9");
        probe = 16'h1234; tick("R10");

        // masked term compare (R1)
        term_write(1, 16'h00FF, 16'h0034);
        load_table(0);
        for (int i = 0; i < 40; i++) begin
            probe = (i % 3 == 0) ? {8'($urandom), 8'h34} : PW'($urandom);
            tick("R1");
        end

        // random terms and table (R7, R10)
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < NT; k++) begin
                logic [PW-1:0] msk;
                msk = PW'($urandom) & PW'($urandom) & PW'($urandom);
                term_write(k, msk, PW'($urandom));
            end
            load_table(0);
            for (int i = 0; i < 200; i++) begin
                logic [PW-1:0] p;
                p = PW'($urandom);
                if (i % 4 == 0) p = probe;
                probe = p;
                tick("R7");
            end
        end

        // rise and fall edges (R4)
        for (int k = 0; k < NT; k++) term_write(k, '0, '0);
        edge_write(0, 16'h00F0, "R4");
        load_table(1);
        for (int i = 0; i < 60; i++) begin probe = PW'($urandom) & 16'h0FF0; tick("R4"); end
        edge_write(1, 16'h0F00, "R4");
        load_table(2);
        for (int i = 0; i < 60; i++) begin probe = PW'($urandom) & 16'h0FF0; tick("R4"); end

        // any change (R5)
        edge_write(2, 16'h8001, "R5");
        load_table(3);
        probe = '0; tick("R5");
        probe = 16'h7FFE; tick("R5");
        probe = 16'h7FFF; tick("R5");
        tick("R5");
        for (int i = 0; i < 60; i++) begin probe = PW'($urandom); tick("R5"); end

        // kind 3 loads no mask (R6)
        edge_write(3, 16'hFFFF, "R6");
        probe = 16'h7FFE; tick("R6");
        probe = 16'h7FFF; tick("R6");
        tick("R6");

        // random edge masks mixed with random tables (R10)
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 4; j++) edge_write(j, PW'($urandom), "R6");
            load_table(0);
            for (int i = 0; i < 200; i++) begin probe = PW'($urandom); tick("R10"); end
        end

        // reset mid-run returns to defaults (R2)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check(hit_o, 1'b0, "R2");
        for (int i = 0; i < 10; i++) begin probe = PW'($urandom); tick("R2"); end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule